// File: doc/BRIEF.md
# NAND Read-Ahead and Write-Behind Byte FIFO Engine

This block sits between a host register port and the data bus of a NAND flash device. It holds a 64-byte FIFO. In read-ahead mode, the host programs a byte count and starts the engine. The engine then fetches bytes from the device before the host asks for them. The host drains the FIFO one byte at a time. When a read brings the fill level down to a programmable threshold, the engine fetches more bytes.

In write-behind mode, the engine forwards each host byte to the device. For a 16-bit device, it first pairs two host bytes into one word. A DMA request line follows the FIFO level. Two sticky status bits report the FIFO level and the end of the transfer. A packed status word exposes the fill level, a threshold flag and the remaining byte count.

Chip-select decoding and the flash device are outside the block. The device width comes in on a plain input.

Top module: `nand_fifo_engine`

## Requirements
- R1: After reset, the outputs take these values:
  - `cfg_rd` = 0x00004000.
  - `xfer_rd`, `status_word`, `irq_stat`, `busy`, `dma_req`, `running`, `nd_wr` and `host_rdata` are all 0.
- R2: A configuration write stores `cfg_wdata & 0x7F8F7FBF`. The configuration fields are:
  - bit 0: write-behind select.
  - bit 2: DMA enable.
  - bit 7: engine enable.
  - bits [14:8]: threshold.
  - bits [26:24]: chip select.

  A configuration write is ignored while `running` is 1. A write to the 14-bit byte count is also ignored while `running` is 1.
- R3: A start (`ctl_we` with `ctl_start`=1 while stopped) does the following:
  - It loads the remaining count from the byte count and sets `running`.
  - In read-ahead mode, it clears the fill level and begins a fetch at once.
  - In write-behind mode, it sets the fill level to 64.
- R4: A fetch moves `min(64 - fill level, remaining)` bytes, rounded down to even for a 16-bit device.
  - It moves one byte per cycle on an 8-bit device, or one word per cycle on a 16-bit device (low byte first).
  - `busy` is high for the whole fetch, and host reads are ignored while `busy` is high.
  - Bytes reach the host in the order they were fetched.
- R5: A refill fetch starts when a host read leaves the fill level equal to 64 minus the threshold.
- R6: The DMA request works as follows:
  - `dma_req` is 0 whenever configuration bit 2 is 0.
  - Otherwise, `dma_req` drops when a refill is triggered.
  - It rises at the end of any fetch that leaves the FIFO non-empty.
- R7: A host read from an empty FIFO returns the last byte again and leaves the fill level at 0. A host read in write-behind mode returns 0.
- R8: On an 8-bit device, each accepted host byte is issued to the device on `nd_wr_data[7:0]` in the next cycle, and the remaining count drops by one. A host write is ignored in read-ahead mode, and also when the remaining count is 0.
- R9: On a 16-bit device in write-behind mode, the pairing works as follows:
  - The first byte is held and the fill level becomes 63; nothing is issued.
  - The second byte issues the word {second, first} and restores the level to 64.
  - The remaining count drops by one per byte.
- R10: `irq_stat` bit 1 (terminal count) is set, and `running` clears, when the remaining count reaches 0 during a write or at the end of a fetch while running. A start with a count of 0 also ends this way.

  `irq_stat` bit 0 is set in the cycle after any cycle in which the fill level is at least the threshold. Writing 1s on `stat_clr` clears the matching bits, and a set in the same cycle wins.
- R11: Stopping (`ctl_start`=0 while running) forces the remaining count to 0. Bytes already in the FIFO can still be read in order.
- R12: `status_word` holds:
  - the fill level in bits [31:24];
  - the flag (fill level ≥ threshold) in bit 16;
  - the remaining count in bits [13:0];
  - zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cnt_we | input | 1 | Byte count write strobe |
| cnt_wdata | input | 14 | Byte count write data |
| ctl_we | input | 1 | Start/stop control write strobe |
| ctl_start | input | 1 | Start bit value written with `ctl_we` |
| stat_clr | input | 2 | Write-1-to-clear for the status bits |
| dev16 | input | 1 | Attached device is 16 bits wide |
| host_rd | input | 1 | Host FIFO read pulse |
| host_rdata | output | 8 | Host read data, valid the cycle after `host_rd` |
| host_wr | input | 1 | Host FIFO write pulse |
| host_wdata | input | 8 | Host write data |
| busy | output | 1 | Fetch in progress; host reads ignored |
| nd_rd_req | output | 1 | Device data read this cycle |
| nd_rd_data | input | 16 | Device read data, sampled when `nd_rd_req` is high |
| nd_wr | output | 1 | Device data write pulse |
| nd_wr_data | output | 16 | Device write data |
| dma_req | output | 1 | DMA request |
| irq_stat | output | 2 | Sticky status: bit 1 terminal count, bit 0 FIFO level event |
| status_word | output | 32 | Packed fill level, threshold flag and remaining count |
| cfg_rd | output | 32 | Configuration word readback |
| xfer_rd | output | 14 | Byte count readback |
| running | output | 1 | Engine started and not yet finished |

## Verification
The bound checker watches several properties on every cycle:
- the fill level never exceeds 64;
- the DMA request stays low while DMA is disabled;
- device reads happen only during a fetch, and each one raises the level by one on an 8-bit device;
- the configuration never changes while the engine runs;
- the level stays at 63 or 64 during write-behind;
- the event bit follows the threshold comparison;
- terminal count always coincides with the engine stopping.

Other behaviours can only be shown by the bench's scenarios:
- the byte order across refills;
- the exact fetch sizes;
- the repeat on an empty read;
- the word pairing;
- the ignored writes;
- draining after a forced stop.

// File: rtl/nfe_pkg.sv
package nfe_pkg;
    localparam int FIFO_DEPTH = 64;
    localparam int ADDR_W     = $clog2(FIFO_DEPTH);
    localparam int LVL_W      = ADDR_W + 1;
    localparam int CNT_W      = 14;
    localparam int THR_W      = 7;
    localparam int THR_LSB    = 8;

    localparam logic [31:0] CFG_MASK  = 32'h7F8F7FBF;
    localparam logic [31:0] CFG_RESET = 32'h0000_4000;

    localparam int BIT_WRMODE = 0;
    localparam int BIT_DMAEN  = 2;
    localparam int STAT_EVT   = 0;
    localparam int STAT_TC    = 1;

    typedef struct packed {
        logic [31:0]      cfg;
        logic [CNT_W-1:0] xfer;
        logic             start;
        logic [CNT_W-1:0] rem;
        logic [LVL_W-1:0] lvl;
        logic [ADDR_W-1:0] head;
        logic [LVL_W-1:0] fill_left;
        logic             busy;
        logic             dma;
        logic [1:0]       stat;
        logic [7:0]       last;
        logic [7:0]       hold;
        logic [7:0]       rdata;
        logic             nd_wr;
        logic [15:0]      nd_wdata;
    } nfe_state_t;
endpackage

// File: rtl/nfe_store.sv
module nfe_store #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_lo,
    input  logic [AW-1:0] wa_lo,
    input  logic [7:0]    wd_lo,
    input  logic          we_hi,
    input  logic [AW-1:0] wa_hi,
    input  logic [7:0]    wd_hi,
    input  logic [AW-1:0] ra,
    output logic [7:0]    rd
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_lo) mem_q[wa_lo] <= wd_lo;
        if (we_hi) mem_q[wa_hi] <= wd_hi;
    end

    assign rd = mem_q[ra];
endmodule

// File: rtl/nfe_fill_len.sv
module nfe_fill_len #(
    parameter int DEPTH = 64,
    parameter int LW    = $clog2(DEPTH) + 1,
    parameter int CW    = 14
) (
    input  logic [LW-1:0] lvl,
    input  logic [CW-1:0] rem,
    input  logic          pair,
    output logic [LW-1:0] len
);
    logic [LW-1:0] space;
    logic [LW-1:0] raw;

    always_comb begin
        space = LW'(DEPTH) - lvl;
        raw   = (rem < CW'(space)) ? rem[LW-1:0] : space;
        len   = pair ? {raw[LW-1:1], 1'b0} : raw;
    end
endmodule

// File: rtl/nand_fifo_engine.sv
module nand_fifo_engine
    import nfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              ctl_we,
    input  logic              ctl_start,
    input  logic [1:0]        stat_clr,
    input  logic              dev16,
    input  logic              host_rd,
    output logic [7:0]        host_rdata,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic              busy,
    output logic              nd_rd_req,
    input  logic [15:0]       nd_rd_data,
    output logic              nd_wr,
    output logic [15:0]       nd_wr_data,
    output logic              dma_req,
    output logic [1:0]        irq_stat,
    output logic [31:0]       status_word,
    output logic [31:0]       cfg_rd,
    output logic [CNT_W-1:0]  xfer_rd,
    output logic              running
);
    nfe_state_t q, d;

    logic [THR_W-1:0]  thr;
    logic [7:0]        head_byte;
    logic              we_lo, we_hi;
    logic [ADDR_W-1:0] wa_lo, wa_hi;
    logic              fill_trig, stop_now;
    logic [LVL_W-1:0]  trig_lvl, fill_len;
    logic [CNT_W-1:0]  trig_rem;
    logic              lvl_hit;

    assign thr   = q.cfg[THR_LSB +: THR_W];
    assign wa_lo = q.head + q.lvl[ADDR_W-1:0];
    assign wa_hi = wa_lo + 1'b1;

    nfe_store #(.DEPTH(FIFO_DEPTH), .AW(ADDR_W)) u_store (
        .clk   (clk),
        .we_lo (we_lo),
        .wa_lo (wa_lo),
        .wd_lo (nd_rd_data[7:0]),
        .we_hi (we_hi),
        .wa_hi (wa_hi),
        .wd_hi (nd_rd_data[15:8]),
        .ra    (q.head),
        .rd    (head_byte)
    );

    nfe_fill_len #(.DEPTH(FIFO_DEPTH), .LW(LVL_W), .CW(CNT_W)) u_len (
        .lvl  (trig_lvl),
        .rem  (trig_rem),
        .pair (dev16),
        .len  (fill_len)
    );

    always_comb begin
        d         = q;
        d.nd_wr   = 1'b0;
        nd_rd_req = 1'b0;
        we_lo     = 1'b0;
        we_hi     = 1'b0;
        fill_trig = 1'b0;
        stop_now  = 1'b0;
        trig_lvl  = q.lvl;
        trig_rem  = q.rem;
        lvl_hit   = 1'b0;

        d.stat = q.stat & ~stat_clr;
        if (q.lvl >= LVL_W'(thr)) d.stat[STAT_EVT] = 1'b1;

        if (cfg_we && !q.start) d.cfg  = cfg_wdata & CFG_MASK;
        if (cnt_we && !q.start) d.xfer = cnt_wdata;

        if (q.busy) begin
            if (q.fill_left != '0) begin
                nd_rd_req = 1'b1;
                we_lo     = 1'b1;
                if (dev16) begin
                    we_hi       = 1'b1;
                    d.lvl       = q.lvl + LVL_W'(2);
                    d.rem       = q.rem - CNT_W'(2);
                    d.fill_left = q.fill_left - LVL_W'(2);
                end else begin
                    d.lvl       = q.lvl + 1'b1;
                    d.rem       = q.rem - 1'b1;
                    d.fill_left = q.fill_left - 1'b1;
                end
            end else begin
                d.busy = 1'b0;
                if (q.start && q.rem == '0) begin
                    d.stat[STAT_TC] = 1'b1;
                    d.start         = 1'b0;
                end
                if (q.lvl != '0) d.dma = 1'b1;
            end
        end else if (host_rd) begin
            if (q.cfg[BIT_WRMODE]) begin
                d.rdata = 8'h00;
            end else begin
                if (q.lvl != '0) begin
                    d.rdata = head_byte;
                    d.last  = head_byte;
                    d.head  = q.head + 1'b1;
                    d.lvl   = q.lvl - 1'b1;
                end else begin
                    d.rdata = q.last;
                end
                lvl_hit = ({1'b0, d.lvl} + {1'b0, LVL_W'(thr)}) == (LVL_W + 1)'(FIFO_DEPTH);
                if (lvl_hit) begin
                    d.dma     = 1'b0;
                    fill_trig = 1'b1;
                    trig_lvl  = d.lvl;
                end
            end
        end

        if (host_wr && q.cfg[BIT_WRMODE] && q.rem != '0) begin
            d.rem = q.rem - 1'b1;
            if (dev16) begin
                if (q.lvl == LVL_W'(FIFO_DEPTH)) begin
                    d.hold = host_wdata;
                    d.lvl  = LVL_W'(FIFO_DEPTH - 1);
                end else begin
                    d.nd_wr    = 1'b1;
                    d.nd_wdata = {host_wdata, q.hold};
                    d.lvl      = LVL_W'(FIFO_DEPTH);
                end
            end else begin
                d.nd_wr    = 1'b1;
                d.nd_wdata = {8'h00, host_wdata};
            end
            if (q.rem == CNT_W'(1)) begin
                d.stat[STAT_TC] = 1'b1;
                d.start         = 1'b0;
            end
        end

        if (ctl_we && ctl_start != q.start) begin
            d.start = ctl_start;
            if (ctl_start) begin
                d.rem  = q.xfer;
                d.head = '0;
                if (q.cfg[BIT_WRMODE]) begin
                    d.lvl = LVL_W'(FIFO_DEPTH);
                end else begin
                    d.lvl     = '0;
                    fill_trig = 1'b1;
                    trig_lvl  = '0;
                    trig_rem  = q.xfer;
                end
            end else begin
                d.rem    = '0;
                stop_now = 1'b1;
            end
        end

        if (fill_trig) begin
            d.busy      = 1'b1;
            d.fill_left = fill_len;
        end
        if (stop_now) d.fill_left = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.cfg <= CFG_RESET;
        end else begin
            q <= d;
        end
    end

    assign host_rdata  = q.rdata;
    assign busy        = q.busy;
    assign nd_wr       = q.nd_wr;
    assign nd_wr_data  = q.nd_wdata;
    assign dma_req     = q.dma & q.cfg[BIT_DMAEN];
    assign irq_stat    = q.stat;
    assign cfg_rd      = q.cfg;
    assign xfer_rd     = q.xfer;
    assign running     = q.start;
    assign status_word = {8'(q.lvl), 7'b0, (q.lvl >= LVL_W'(thr)), 2'b0, q.rem};
endmodule

// File: rtl/nfe_chk.sv
module nfe_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cfg_rd,
    input logic [31:0] status_word,
    input logic [1:0]  irq_stat,
    input logic        running,
    input logic        busy,
    input logic        dma_req,
    input logic        nd_rd_req,
    input logic        dev16
);
    logic [7:0] lvl;
    logic [7:0] thr;
    assign lvl = status_word[31:24];
    assign thr = {1'b0, cfg_rd[14:8]};

    p_lvl_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= 8'd64);

    p_rd_in_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nd_rd_req |-> busy);

    p_byte_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nd_rd_req && !dev16) |=> (lvl == $past(lvl) + 8'd1));

    p_dma_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd[2] |-> !dma_req);

    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(running) |-> $stable(cfg_rd));

    p_wb_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cfg_rd[0]) |-> (lvl >= 8'd63));

    p_event_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl >= thr) |=> irq_stat[0]);

    p_tc_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_stat[1]) |-> !running);
endmodule

bind nand_fifo_engine nfe_chk u_chk (.*);

// File: tb/sim_nand_fifo_engine.sv
`timescale 1ns/1ps
module sim_nand_fifo_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        cnt_we = 1'b0;
    logic [13:0] cnt_wdata = '0;
    logic        ctl_we = 1'b0;
    logic        ctl_start = 1'b0;
    logic [1:0]  stat_clr = '0;
    logic        dev16 = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic        busy, nd_rd_req, nd_wr, dma_req, running;
    logic [15:0] nd_rd_data, nd_wr_data;
    logic [1:0]  irq_stat;
    logic [31:0] status_word, cfg_rd;
    logic [13:0] xfer_rd;

    always #2.5 clk = ~clk;

    nand_fifo_engine u0 (.*);

    // device model: byte stream bc, bc+1, ...
    logic [7:0] bc = 8'h00;
    assign nd_rd_data = dev16 ? {bc + 8'd1, bc} : {8'h00, bc};
    always @(posedge clk) if (nd_rd_req) bc <= bc + (dev16 ? 8'd2 : 8'd1);

    // device write log
    logic [15:0] wlog [16];
    int wn = 0;
    always @(negedge clk) if (nd_wr && wn < 16) begin wlog[wn] = nd_wr_data; wn++; end

    int nvec = 0, nmis = 0;
    bit done = 0;
    logic [7:0] eb = 8'h00;

    // {count[13:0], threshold[6:0], dev16, dma_en}
    localparam bit [22:0] VEC [0:5] = '{
        {14'd10,  7'd8,  1'b0, 1'b1},
        {14'd64,  7'd64, 1'b0, 1'b1},
        {14'd100, 7'd16, 1'b0, 1'b1},
        {14'd130, 7'd40, 1'b1, 1'b1},
        {14'd7,   7'd1,  1'b0, 1'b0},
        {14'd40,  7'd64, 1'b1, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nmis++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask
    task automatic wait_idle(); while (busy) @(negedge clk); endtask

    task automatic wr_cfg(input logic [31:0] v);
        cfg_we = 1; cfg_wdata = v; tick(); cfg_we = 0;
    endtask
    task automatic wr_cnt(input logic [13:0] v);
        cnt_we = 1; cnt_wdata = v; tick(); cnt_we = 0;
    endtask
    task automatic wr_ctl(input logic v);
        ctl_we = 1; ctl_start = v; tick(); ctl_we = 0;
    endtask
    task automatic clr_stat();
        stat_clr = 2'b11; tick(); stat_clr = 2'b00;
    endtask
    task automatic hrd();
        host_rd = 1; tick(); host_rd = 0;
    endtask
    task automatic hwr(input logic [7:0] v);
        host_wr = 1; host_wdata = v; tick(); host_wr = 0;
    endtask

    task automatic run_entry(input bit [22:0] e);
        int xfer, thr, exp_fill, got;
        bit d16, den;
        xfer = int'(e[22:9]); thr = int'(e[8:2]); d16 = e[1]; den = e[0];
        dev16 = d16;
        clr_stat();
        wr_cfg(32'(thr << 8) | 32'h80 | (den ? 32'h4 : 32'h0));
        wr_cnt(14'(xfer));
        wr_ctl(1'b1);
        wait_idle();
        exp_fill = (xfer < 64) ? xfer : 64;
        chk(status_word[31:24] == 8'(exp_fill), "R3 R4 fill level", status_word[31:24], exp_fill);
        chk(status_word[13:0] == 14'(xfer - exp_fill), "R12 remaining field", status_word[13:0], xfer - exp_fill);
        chk(status_word[16] == (exp_fill >= thr), "R12 threshold flag", status_word[16], exp_fill >= thr);
        chk(dma_req == den, "R6 dma after fetch", dma_req, den);
        chk(irq_stat[0] == (exp_fill >= thr), "R10 event bit", irq_stat[0], exp_fill >= thr);
        got = 0;
        while (got < xfer) begin
            hrd();
            chk(host_rdata == eb, "R5 R4 byte order", host_rdata, eb);
            eb++; got++;
            wait_idle();
        end
        chk(irq_stat[1] == 1'b1 && running == 1'b0, "R10 terminal count", {irq_stat[1], running}, 2'b10);
        chk(status_word[31:24] == 8'd0, "R5 drained", status_word[31:24], 0);
    endtask

    initial begin
        repeat (3) tick();
        // R1 reset values
        chk(cfg_rd == 32'h4000, "R1 cfg reset", cfg_rd, 32'h4000);
        chk(status_word == 0 && irq_stat == 0 && xfer_rd == 0, "R1 status reset", status_word, 0);
        chk({busy, dma_req, running, nd_wr} == 4'b0 && host_rdata == 0, "R1 control reset", {busy, dma_req, running, nd_wr}, 0);
        rst_n = 1; tick();
        // R2 write mask
        wr_cfg(32'hFFFF_FFFF);
        chk(cfg_rd == 32'h7F8F7FBF, "R2 cfg mask", cfg_rd, 32'h7F8F7FBF);

        // vector table: read-ahead transfers
        foreach (VEC[i]) run_entry(VEC[i]);

        // R7 empty read repeats last byte
        hrd();
        chk(host_rdata == eb - 8'd1, "R7 empty repeat", host_rdata, eb - 8'd1);
        wait_idle();
        chk(status_word[31:24] == 0, "R7 level stays 0", status_word[31:24], 0);

        // 8-bit write-behind
        dev16 = 0; clr_stat();
        wr_cfg(32'h0000_0001);
        wr_cnt(14'd3);
        wr_ctl(1'b1);
        chk(status_word[31:24] == 8'd64 && running, "R3 write start level", status_word[31:24], 64);
        wr_cfg(32'h0000_0000);
        chk(cfg_rd == 32'h1, "R2 cfg frozen", cfg_rd, 1);
        wr_cnt(14'd9);
        chk(xfer_rd == 14'd3, "R2 count frozen", xfer_rd, 3);
        hrd();
        chk(host_rdata == 8'h00, "R7 read in write mode", host_rdata, 0);
        hwr(8'hA5); hwr(8'h5A); hwr(8'hC3); tick();
        chk(wn == 3, "R8 byte writes issued", wn, 3);
        chk(wlog[0] == 16'h00A5 && wlog[1] == 16'h005A && wlog[2] == 16'h00C3, "R8 write data", wlog[2], 16'h00C3);
        chk(irq_stat[1] && !running && status_word[13:0] == 0, "R10 tc on write", {irq_stat[1], running}, 2'b10);
        hwr(8'h77); tick();
        chk(wn == 3, "R8 write after count 0 ignored", wn, 3);

        // 16-bit write-behind pairing
        dev16 = 1; clr_stat();
        wr_cnt(14'd4);
        wr_ctl(1'b1);
        hwr(8'h11); tick();
        chk(status_word[31:24] == 8'd63 && wn == 3, "R9 first byte held", status_word[31:24], 63);
        hwr(8'h22); tick();
        chk(wn == 4 && wlog[3] == 16'h2211, "R9 word issued", wlog[3], 16'h2211);
        chk(status_word[31:24] == 8'd64, "R9 level back to 64", status_word[31:24], 64);
        hwr(8'h33); hwr(8'h44); tick();
        chk(wn == 5 && wlog[4] == 16'h4433, "R9 second word", wlog[4], 16'h4433);
        chk(irq_stat[1] && !running, "R10 tc on paired write", {irq_stat[1], running}, 2'b10);

        // write in read-ahead mode ignored; zero count start
        dev16 = 0; clr_stat();
        wr_cfg(32'h0000_1080);
        wr_cnt(14'd0);
        wr_ctl(1'b1);
        wait_idle();
        chk(irq_stat[1] && !running, "R10 tc on zero count", {irq_stat[1], running}, 2'b10);
        hwr(8'h99); tick();
        chk(wn == 5, "R8 write in read mode ignored", wn, 5);

        // forced stop then drain
        clr_stat();
        wr_cnt(14'd200);
        wr_ctl(1'b1);
        wait_idle();
        wr_ctl(1'b0);
        chk(status_word[13:0] == 0 && !running, "R11 stop clears count", status_word[13:0], 0);
        for (int k = 0; k < 64; k++) begin
            hrd();
            chk(host_rdata == eb, "R11 drain after stop", host_rdata, eb);
            eb++;
            wait_idle();
        end
        chk(status_word[31:24] == 0 && irq_stat[1] == 0, "R11 no tc after stop", {status_word[31:24], irq_stat[1]}, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nvec++; nmis++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    end
endmodule